// File: doc/BRIEF.md
# Exception Control Register Bank

This block holds the small set of system-control registers that an exception handler relies on. These are a status word, a cause word, the exception return address, the faulting address of the last address-related fault, and a free-running cycle counter. Software reaches every register by a 5-bit register number. Writes go through a move-to port (`sw_wen`, `sw_addr`, `sw_wdata`). Reads go through a combinational move-from port (`sw_raddr` → `sw_rdata`).

The pipeline reports a fault with a one-cycle `exc_valid` strobe. The strobe carries a 5-bit cause code, the PC of the faulting instruction and, for address faults, the address involved. On that edge the bank captures these values and enters handler mode. A one-cycle `eret` strobe leaves handler mode again.

Handler mode is kept by a two-state machine:
- **MODE_NORMAL** goes to **MODE_HANDLER** on transition *TAKE* (`exc_valid`).
- **MODE_HANDLER** goes to **MODE_NORMAL** on transition *RETURN* (`eret` without `exc_valid`).
- **MODE_HANDLER** stays in **MODE_HANDLER** on transition *NEST* (`exc_valid`, with or without `eret`).
- **MODE_NORMAL** stays in **MODE_NORMAL** on transition *IDLE* (no `exc_valid`; a stray `eret` falls here).

The state is visible as Status bit 1 and on the `exc_level` output.

Top module: `exc_ctrl_bank`

## Requirements
- R1: While reset is asserted, every implemented register reads 0 and `exc_level` is 0.
- R2: Register numbers 8 (fault address), 9 (counter), 12 (status), 13 (cause) and 14 (return PC) read their register on `sw_rdata` in the same cycle. Every other number reads 0.
- R3: A software write takes effect at the next rising edge and is readable after that edge. A write to a number that is not implemented changes no implemented register.
- R4: On `exc_valid`, the next edge loads the return-PC register with `exc_pc`. The same edge loads Cause bits 6:2 with `exc_code` and clears the other Cause bits.
- R5: The fault-address register loads `exc_addr` only when `exc_valid` carries a code from 1 to 5 (address-related). For any other code it keeps its value.
- R6: `exc_valid` sets the handler level (MODE_HANDLER). `eret` alone clears it. When both arrive together, the level stays set. `eret` in MODE_NORMAL has no effect.
- R7: Status bit 1 always reads the handler level and ignores software writes. Every other Status bit takes the written value.
- R8: The counter increments by one every cycle. A software write to number 9 loads the written value instead of the increment in that cycle.
- R9: When an exception capture and a software write target the same register in one cycle, the captured value wins. A software write to the fault-address register still lands if the simultaneous exception is not address-related.
- R10: A software write to Cause changes only bits 6:2. All other Cause bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | One-cycle exception strobe |
| exc_code | input | 5 | Cause code of the exception |
| exc_pc | input | W | PC of the faulting instruction |
| exc_addr | input | W | Address involved in an address fault |
| eret | input | 1 | Return-from-exception strobe |
| sw_wen | input | 1 | Software write enable |
| sw_addr | input | 5 | Register number for the write |
| sw_wdata | input | W | Write data |
| sw_raddr | input | 5 | Register number for the read |
| sw_rdata | output | W | Read data, combinational |
| exc_level | output | 1 | 1 while in handler mode |

## Verification
The hardest case to reach is an exception and a software write landing on the same register in the same cycle. A second hard case is an exception and `eret` arriving together while the bank is already in handler mode. The directed tasks drive these inputs on the same falling edge, so they share one rising edge. Each task then reads the affected registers back. The fault-address case is run twice, once with an address-related code and once with a plain code. This separates "capture wins" from "software write lands".

// File: rtl/exc_bank_pkg.sv
package exc_bank_pkg;
    localparam int RN_W     = 5;
    localparam int CODE_W   = 5;
    localparam int CODE_LSB = 2;
    localparam int LVL_BIT  = 1;

    localparam logic [RN_W-1:0] RN_FADDR  = 5'd8;
    localparam logic [RN_W-1:0] RN_COUNT  = 5'd9;
    localparam logic [RN_W-1:0] RN_STATUS = 5'd12;
    localparam logic [RN_W-1:0] RN_CAUSE  = 5'd13;
    localparam logic [RN_W-1:0] RN_RETPC  = 5'd14;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    function automatic logic is_addr_fault(input logic [CODE_W-1:0] code);
        return (code >= 5'd1) && (code <= 5'd5);
    endfunction

    function automatic logic is_known(input logic [RN_W-1:0] rn);
        return (rn == RN_FADDR) || (rn == RN_COUNT) || (rn == RN_STATUS) ||
               (rn == RN_CAUSE) || (rn == RN_RETPC);
    endfunction
endpackage

// File: rtl/excbank_mode.sv
module excbank_mode
    import exc_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exc_valid,
    input  logic         eret,
    input  logic         wr_status,
    input  logic [W-1:0] wdata,
    output logic         level,
    output logic [W-1:0] status_rd
);
    mode_e        state_q, state_d;
    logic [W-1:0] status_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_NORMAL;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL:  if (exc_valid)  state_d = MODE_HANDLER;
            MODE_HANDLER: if (exc_valid)  state_d = MODE_HANDLER;
                          else if (eret)  state_d = MODE_NORMAL;
        endcase
    end

    // software-owned status bits
    always_ff @(posedge clk) begin
        if (!rst_n)         status_q <= '0;
        else if (wr_status) status_q <= wdata;
    end

    // outputs
    always_comb begin
        level              = (state_q == MODE_HANDLER);
        status_rd          = status_q;
        status_rd[LVL_BIT] = level;
    end
endmodule

// File: rtl/excbank_capture.sv
module excbank_capture
    import exc_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [W-1:0]      exc_pc,
    input  logic [W-1:0]      exc_addr,
    input  logic              wr_retpc,
    input  logic              wr_cause,
    input  logic              wr_faddr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      retpc_q,
    output logic [W-1:0]      cause_rd,
    output logic [W-1:0]      faddr_q
);
    logic [CODE_W-1:0] code_q;
    logic              take_addr;

    assign take_addr = exc_valid && is_addr_fault(exc_code);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retpc_q <= '0;
            code_q  <= '0;
            faddr_q <= '0;
        end else begin
            if (exc_valid)     retpc_q <= exc_pc;
            else if (wr_retpc) retpc_q <= wdata;

            if (exc_valid)     code_q <= exc_code;
            else if (wr_cause) code_q <= wdata[CODE_LSB +: CODE_W];

            if (take_addr)     faddr_q <= exc_addr;
            else if (wr_faddr) faddr_q <= wdata;
        end
    end

    always_comb begin
        cause_rd                       = '0;
        cause_rd[CODE_LSB +: CODE_W]   = code_q;
    end
endmodule

// File: rtl/excbank_timer.sv
module excbank_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= wdata;
        else           cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/exc_ctrl_bank.sv
module exc_ctrl_bank
    import exc_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exc_valid,
    input  logic [4:0]   exc_code,
    input  logic [W-1:0] exc_pc,
    input  logic [W-1:0] exc_addr,
    input  logic         eret,
    input  logic         sw_wen,
    input  logic [4:0]   sw_addr,
    input  logic [W-1:0] sw_wdata,
    input  logic [4:0]   sw_raddr,
    output logic [W-1:0] sw_rdata,
    output logic         exc_level
);
    logic [W-1:0] status_rd, cause_rd, retpc_q, faddr_q, cnt_q;
    logic         wr_status, wr_cause, wr_retpc, wr_faddr, wr_count;

    assign wr_status = sw_wen && (sw_addr == RN_STATUS);
    assign wr_cause  = sw_wen && (sw_addr == RN_CAUSE);
    assign wr_retpc  = sw_wen && (sw_addr == RN_RETPC);
    assign wr_faddr  = sw_wen && (sw_addr == RN_FADDR);
    assign wr_count  = sw_wen && (sw_addr == RN_COUNT);

    excbank_mode #(.W(W)) u_mode (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .eret(eret),
        .wr_status(wr_status), .wdata(sw_wdata),
        .level(exc_level), .status_rd(status_rd)
    );

    excbank_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_addr(exc_addr),
        .wr_retpc(wr_retpc), .wr_cause(wr_cause), .wr_faddr(wr_faddr),
        .wdata(sw_wdata), .retpc_q(retpc_q), .cause_rd(cause_rd), .faddr_q(faddr_q)
    );

    excbank_timer #(.W(W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(wr_count), .wdata(sw_wdata), .cnt_q(cnt_q)
    );

    always_comb begin
        case (sw_raddr)
            RN_FADDR:  sw_rdata = faddr_q;
            RN_COUNT:  sw_rdata = cnt_q;
            RN_STATUS: sw_rdata = status_rd;
            RN_CAUSE:  sw_rdata = cause_rd;
            RN_RETPC:  sw_rdata = retpc_q;
            default:   sw_rdata = '0;
        endcase
    end
endmodule

// File: rtl/excbank_chk.sv
module excbank_chk
    import exc_bank_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         exc_valid,
    input logic [4:0]   exc_code,
    input logic [W-1:0] exc_pc,
    input logic         eret,
    input logic         sw_wen,
    input logic [4:0]   sw_addr,
    input logic [W-1:0] sw_wdata,
    input logic [4:0]   sw_raddr,
    input logic [W-1:0] sw_rdata,
    input logic         exc_level,
    input logic [W-1:0] cnt,
    input logic [W-1:0] retpc,
    input logic [W-1:0] faddr
);
    // R6
    enter_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> exc_level);
    // R6
    leave_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_valid) |=> !exc_level);
    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_wen && sw_addr == RN_COUNT) |=> cnt == $past(cnt) + W'(1));
    // R8
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wen && sw_addr == RN_COUNT) |=> cnt == $past(sw_wdata));
    // R4
    retpc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> retpc == $past(exc_pc));
    // R5
    faddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(exc_valid && is_addr_fault(exc_code)) && !(sw_wen && sw_addr == RN_FADDR))
        |=> $stable(faddr));
    // R2
    unknown_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_known(sw_raddr) |-> sw_rdata == '0);
endmodule

bind exc_ctrl_bank excbank_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .eret(eret), .sw_wen(sw_wen), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_raddr(sw_raddr), .sw_rdata(sw_rdata),
    .exc_level(exc_level), .cnt(cnt_q), .retpc(retpc_q), .faddr(faddr_q)
);

// File: tb/tb_exc_ctrl_bank.sv
module tb_exc_ctrl_bank;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         exc_valid, eret, sw_wen;
    logic [4:0]   exc_code, sw_addr, sw_raddr;
    logic [W-1:0] exc_pc, exc_addr, sw_wdata, sw_rdata;
    logic         exc_level;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    exc_ctrl_bank #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_addr(exc_addr), .eret(eret), .sw_wen(sw_wen),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_raddr(sw_raddr),
        .sw_rdata(sw_rdata), .exc_level(exc_level)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] rn, input string req, input logic [W-1:0] exp);
        sw_raddr = rn;
        #0.5;
        check(req, sw_rdata, exp);
    endtask

    task automatic idle_inputs();
        exc_valid = 0; eret = 0; sw_wen = 0;
        exc_code = '0; exc_pc = '0; exc_addr = '0;
        sw_addr = '0; sw_wdata = '0;
    endtask

    // drive on falling edge, one rising edge, then settle
    task automatic step();
        @(posedge clk); #1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic sw_write(input logic [4:0] rn, input logic [W-1:0] v);
        sw_wen = 1; sw_addr = rn; sw_wdata = v;
        step();
    endtask

    task automatic t_reset();
        rd(5'd8,  "R1 faddr",  '0);
        rd(5'd9,  "R1 count",  '0);
        rd(5'd12, "R1 status", '0);
        rd(5'd13, "R1 cause",  '0);
        rd(5'd14, "R1 retpc",  '0);
        check("R1 level", {31'd0, exc_level}, '0);
    endtask

    task automatic t_readwrite();
        sw_write(5'd12, 32'hFFFF_FFFF);
        rd(5'd12, "R7 status bit1 ignores write", 32'hFFFF_FFFD);
        sw_write(5'd14, 32'h0000_1234);
        rd(5'd14, "R3 retpc write", 32'h0000_1234);
        sw_write(5'd8, 32'hCAFE_0000);
        rd(5'd8, "R3 faddr write", 32'hCAFE_0000);
        sw_write(5'd13, 32'hFFFF_FFFF);
        rd(5'd13, "R10 cause field only", 32'h0000_007C);
        sw_write(5'd5, 32'hA5A5_A5A5);
        rd(5'd5,  "R2 unknown reads zero", '0);
        rd(5'd14, "R3 unknown write ignored retpc", 32'h0000_1234);
        rd(5'd8,  "R3 unknown write ignored faddr", 32'hCAFE_0000);
        rd(5'd12, "R3 unknown write ignored status", 32'hFFFF_FFFD);
        rd(5'd31, "R2 number 31 reads zero", '0);
    endtask

    task automatic t_count();
        sw_write(5'd9, 32'd100);
        rd(5'd9, "R8 count load wins", 32'd100);
        repeat (5) step();
        rd(5'd9, "R8 count increments", 32'd105);
    endtask

    task automatic t_exception();
        exc_valid = 1; exc_code = 5'd4; exc_pc = 32'h400; exc_addr = 32'hBEEF;
        step();
        rd(5'd14, "R4 retpc captured", 32'h400);
        rd(5'd13, "R4 cause code", 32'h10);
        rd(5'd8,  "R5 faddr captured", 32'hBEEF);
        rd(5'd12, "R7 status shows level", 32'hFFFF_FFFF);
        check("R6 level set", {31'd0, exc_level}, 32'd1);
        exc_valid = 1; exc_code = 5'd8; exc_pc = 32'h500; exc_addr = 32'hDEAD;
        step();
        rd(5'd8,  "R5 faddr kept for plain code", 32'hBEEF);
        rd(5'd13, "R4 cause code 8", 32'h20);
        eret = 1;
        step();
        check("R6 eret clears", {31'd0, exc_level}, 32'd0);
        eret = 1;
        step();
        check("R6 eret in normal", {31'd0, exc_level}, 32'd0);
        rd(5'd14, "R6 eret in normal keeps retpc", 32'h500);
        exc_valid = 1; exc_code = 5'd0; exc_pc = 32'h600; eret = 1;
        step();
        check("R6 take with eret", {31'd0, exc_level}, 32'd1);
        exc_valid = 1; exc_code = 5'd0; exc_pc = 32'h604; eret = 1;
        step();
        check("R6 nest with eret", {31'd0, exc_level}, 32'd1);
        eret = 1;
        step();
    endtask

    task automatic t_conflict();
        exc_valid = 1; exc_code = 5'd2; exc_pc = 32'h800; exc_addr = 32'h77;
        sw_wen = 1; sw_addr = 5'd14; sw_wdata = 32'h111;
        step();
        rd(5'd14, "R9 capture beats retpc write", 32'h800);
        exc_valid = 1; exc_code = 5'd3; exc_pc = 32'h804; exc_addr = 32'h99;
        sw_wen = 1; sw_addr = 5'd8; sw_wdata = 32'h55;
        step();
        rd(5'd8, "R9 capture beats faddr write", 32'h99);
        exc_valid = 1; exc_code = 5'd9; exc_pc = 32'h808; exc_addr = 32'h33;
        sw_wen = 1; sw_addr = 5'd8; sw_wdata = 32'h55;
        step();
        rd(5'd8, "R9 faddr write lands on plain code", 32'h55);
        exc_valid = 1; exc_code = 5'd6; exc_pc = 32'h80C;
        sw_wen = 1; sw_addr = 5'd13; sw_wdata = 32'h7C;
        step();
        rd(5'd13, "R9 capture beats cause write", 32'h18);
    endtask

    initial begin
        idle_inputs();
        sw_raddr = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        t_readwrite();
        t_count();
        t_exception();
        t_conflict();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #40000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule